// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit runs one atomic read-modify-write sequence on a simple synchronous memory port. A request carries a 5-bit function code, a byte address, an operand size (32 or 64 bits), a flag that selects the store form or the fetch form, and two register operands. The unit reads the target word, and for the bounded and twin functions also a neighbouring word. It computes the new value, writes it back when the function calls for a write, and returns the original value at the target address for fetch forms. The operand size in bytes, called the step (4 or 8), sets the offset to the neighbouring word.

While a sequence runs, `busy` stays high. The surrounding memory arbiter holds off all other traffic during that time, so the read and the write act as one locked operation. A 32-bit operation uses the low 32 bits of every data path and returns its value zero-extended.

The controller is a state machine with these states:
- `S_IDLE` waits for a request.
- `S_RD0` reads the lower word.
- `S_RD1` captures the lower word and reads the upper word. Only paired functions visit it.
- `S_LATCH` captures the last read.
- `S_WR0` computes the new value and writes the target when needed.
- `S_WR1` writes the second word. Only the store-twin function visits it.
- `S_FIN` pulses `done`.

The transitions are:
- accept: `S_IDLE` to `S_RD0`, or `S_IDLE` to `S_FIN` for an undefined code.
- `S_RD0` to `S_RD1` for a paired function, otherwise `S_RD0` to `S_LATCH`.
- `S_RD1` to `S_LATCH`.
- `S_LATCH` to `S_WR0`.
- `S_WR0` to `S_WR1` for store-twin, otherwise `S_WR0` to `S_FIN`.
- `S_WR1` to `S_FIN`.
- `S_FIN` to `S_IDLE`.

Top module: `amo_unit`

## Requirements
- R1: After reset `busy`, `done`, `illegal` and `mem_en` are all 0.
- R2: In the fetch form, codes 00000 to 00111 replace the word at EA with, in this order: old+A (wrapping), old XOR A, old OR A, old AND A, unsigned max, signed max, unsigned min and signed min of old and A. A is `req_opa`. The result is the old word.
- R3: Fetch code 01000 (swap) writes A to EA and returns the old word.
- R4: Fetch code 10000 returns the old word and writes `req_opb` to EA only when the old word differs from A. Otherwise memory is left unchanged.
- R5: Fetch code 11000 reads EA and EA+step. When the two words differ, it writes old+1 to EA and returns the old word. When they are equal, it writes nothing and returns the most-negative value of the size.
- R6: Fetch code 11001 reads EA and EA+step. When the two words are equal, it writes old+1 to EA and returns the old word. When they differ, it writes nothing and returns the most-negative value.
- R7: Fetch code 11100 reads EA-step and EA. When they differ, it writes old-1 to EA and returns the old word at EA. When they are equal, it returns the most-negative value. The word at EA-step is never written.
- R8: The store form (`req_store`=1) of codes 00000 to 00111 makes the same memory update as the fetch form and returns zero.
- R9: Store code 11000 (store-twin) reads EA and EA+step. When the two are equal, it writes A to both words. When they differ, it writes nothing. It returns zero.
- R10: Any other code, or a store form of 01000, 10000, 11001 or 11100, makes no memory access. It gives `done` together with `illegal` one cycle after acceptance and returns zero.
- R11: All reads come before any write. `done` rises 4 cycles after the acceptance edge for single-word functions, 5 cycles for paired functions, 6 cycles for store-twin and 1 cycle for undefined codes.
- R12: `busy` is high from the cycle after acceptance through the `done` cycle. `mem_en` is high only while `busy` is high. `req_valid` has no effect while `busy` is high.
- R13: For a 32-bit size the step is 4. Only the low 32 bits of memory and operands are used, signed compares use bit 31 as the sign, the result is zero-extended and the most-negative value is 0x8000_0000. Bytes beyond the word are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken in `S_IDLE` |
| req_func | input | 5 | Function code |
| req_store | input | 1 | 1 = store form, 0 = fetch form |
| req_dw | input | 1 | 1 = 64-bit size, 0 = 32-bit size |
| req_addr | input | ADDR_W | Byte address EA |
| req_opa | input | DATA_W | First operand (A) |
| req_opb | input | DATA_W | Second operand (replacement for code 10000) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Undefined code, valid with `done` |
| result | output | DATA_W | Returned value, valid with `done` |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_dw | output | 1 | Access size, 1 = 8 bytes, 0 = 4 bytes |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The hardest situations to reach are the failing branches of the bounded functions, where the two neighbouring words must already be equal (or, for increment-equal, unequal) before the sequence starts. The stimulus preloads the bench memory so that the pair compares both ways, and it checks that the word at EA and its neighbour are both left intact. A second awkward case is a fresh request that arrives in the middle of a sequence. The bench holds `req_valid` high with a different code and address while `busy` is high, then checks that the second address is left unchanged.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_XOR, K_OR, K_AND,
        K_UMAX, K_SMAX, K_UMIN, K_SMIN,
        K_SWAP, K_CSNE, K_INCB, K_INCE,
        K_DECB, K_TWIN, K_ILL
    } amo_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_LATCH, S_WR0, S_WR1, S_FIN
    } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [4:0] func,
    input  logic       store,
    output amo_kind_e  kind,
    output logic       pair,
    output logic       down,
    output logic       legal
);

    always_comb begin
        case (func)
            5'b00000: kind = K_ADD;
            5'b00001: kind = K_XOR;
            5'b00010: kind = K_OR;
            5'b00011: kind = K_AND;
            5'b00100: kind = K_UMAX;
            5'b00101: kind = K_SMAX;
            5'b00110: kind = K_UMIN;
            5'b00111: kind = K_SMIN;
            5'b01000: kind = store ? K_ILL : K_SWAP;
            5'b10000: kind = store ? K_ILL : K_CSNE;
            5'b11000: kind = store ? K_TWIN : K_INCB;
            5'b11001: kind = store ? K_ILL : K_INCE;
            5'b11100: kind = store ? K_ILL : K_DECB;
            default:  kind = K_ILL;
        endcase
    end

    assign pair  = (kind == K_INCB) || (kind == K_INCE) ||
                   (kind == K_DECB) || (kind == K_TWIN);
    assign down  = (kind == K_DECB);
    assign legal = (kind != K_ILL);

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_kind_e          kind,
    input  logic               dw,
    input  logic [DATA_W-1:0]  w0,
    input  logic [DATA_W-1:0]  w1,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic [DATA_W-1:0]  new_val,
    output logic [DATA_W-1:0]  ret_val,
    output logic               wr
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mask, min_neg, old, a, ko, ka;
    logic              s_gt;

    assign mask    = dw ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign min_neg = dw ? {1'b1, {(DATA_W-1){1'b0}}}
                        : {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
    assign old     = (kind == K_DECB) ? w1 : w0;
    assign a       = opa & mask;
    assign ko      = dw ? old : {{HALF_W{old[HALF_W-1]}}, old[HALF_W-1:0]};
    assign ka      = dw ? a   : {{HALF_W{a[HALF_W-1]}},   a[HALF_W-1:0]};
    assign s_gt    = $signed(ko) > $signed(ka);

    always_comb begin
        new_val = '0;
        ret_val = old;
        wr      = 1'b0;
        unique case (kind)
            K_ADD:  begin new_val = (old + a) & mask;     wr = 1'b1; end
            K_XOR:  begin new_val = old ^ a;              wr = 1'b1; end
            K_OR:   begin new_val = old | a;              wr = 1'b1; end
            K_AND:  begin new_val = old & a;              wr = 1'b1; end
            K_UMAX: begin new_val = (old > a) ? old : a;  wr = 1'b1; end
            K_SMAX: begin new_val = s_gt ? old : a;       wr = 1'b1; end
            K_UMIN: begin new_val = (old < a) ? old : a;  wr = 1'b1; end
            K_SMIN: begin new_val = s_gt ? a : old;       wr = 1'b1; end
            K_SWAP: begin new_val = a;                    wr = 1'b1; end
            K_CSNE: begin new_val = opb & mask;           wr = (old != a); end
            K_INCB: begin
                new_val = (old + 1'b1) & mask;
                wr      = (w0 != w1);
                if (w0 == w1) ret_val = min_neg;
            end
            K_INCE: begin
                new_val = (old + 1'b1) & mask;
                wr      = (w0 == w1);
                if (w0 != w1) ret_val = min_neg;
            end
            K_DECB: begin
                new_val = (old - 1'b1) & mask;
                wr      = (w0 != w1);
                if (w0 == w1) ret_val = min_neg;
            end
            K_TWIN: begin new_val = a;                    wr = (w0 == w1); end
            default: ret_val = '0;
        endcase
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_func,
    input  logic              req_store,
    input  logic              req_dw,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_opa,
    input  logic [DATA_W-1:0] req_opb,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] result,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_dw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int HALF_W = DATA_W / 2;
    localparam int BYTES  = DATA_W / 8;

    amo_state_e        state, state_nx;
    amo_kind_e         dec_kind, q_kind;
    logic              dec_pair, dec_down, dec_legal;
    logic              q_pair, q_down, q_ill, q_store, q_dw, q_twin_wr;
    logic [ADDR_W-1:0] q_ea, step, addr_lo, addr_hi;
    logic [DATA_W-1:0] q_opa, q_opb, q_w0, q_w1, q_res, mask, rd_m;
    logic [DATA_W-1:0] alu_new, alu_ret;
    logic              alu_wr;

    amo_decode u_dec (
        .func  (req_func),
        .store (req_store),
        .kind  (dec_kind),
        .pair  (dec_pair),
        .down  (dec_down),
        .legal (dec_legal)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .kind    (q_kind),
        .dw      (q_dw),
        .w0      (q_w0),
        .w1      (q_w1),
        .opa     (q_opa),
        .opb     (q_opb),
        .new_val (alu_new),
        .ret_val (alu_ret),
        .wr      (alu_wr)
    );

    assign mask    = q_dw ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign rd_m    = mem_rdata & mask;
    assign step    = q_dw ? ADDR_W'(BYTES) : ADDR_W'(BYTES / 2);
    assign addr_lo = q_down ? q_ea - step : q_ea;
    assign addr_hi = q_down ? q_ea : q_ea + step;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = dec_legal ? S_RD0 : S_FIN;
            S_RD0:   state_nx = q_pair ? S_RD1 : S_LATCH;
            S_RD1:   state_nx = S_LATCH;
            S_LATCH: state_nx = S_WR0;
            S_WR0:   state_nx = (q_kind == K_TWIN) ? S_WR1 : S_FIN;
            S_WR1:   state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Request and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_kind    <= K_ILL;
            q_pair    <= 1'b0;
            q_down    <= 1'b0;
            q_ill     <= 1'b0;
            q_store   <= 1'b0;
            q_dw      <= 1'b0;
            q_twin_wr <= 1'b0;
            q_ea      <= '0;
            q_opa     <= '0;
            q_opb     <= '0;
            q_w0      <= '0;
            q_w1      <= '0;
            q_res     <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    q_kind  <= dec_kind;
                    q_pair  <= dec_pair;
                    q_down  <= dec_down;
                    q_ill   <= !dec_legal;
                    q_store <= req_store;
                    q_dw    <= req_dw;
                    q_ea    <= req_addr;
                    q_opa   <= req_opa;
                    q_opb   <= req_opb;
                    q_res   <= '0;
                end
                S_RD1:   q_w0 <= rd_m;
                S_LATCH: if (q_pair) q_w1 <= rd_m;
                         else        q_w0 <= rd_m;
                S_WR0: begin
                    q_res     <= q_store ? '0 : alu_ret;
                    q_twin_wr <= alu_wr;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q_ea;
        mem_wdata = '0;
        unique case (state)
            S_RD0: begin mem_en = 1'b1; mem_addr = addr_lo; end
            S_RD1: begin mem_en = 1'b1; mem_addr = addr_hi; end
            S_WR0: begin
                mem_en    = alu_wr;
                mem_we    = alu_wr;
                mem_addr  = q_ea;
                mem_wdata = alu_new;
            end
            S_WR1: begin
                mem_en    = q_twin_wr;
                mem_we    = q_twin_wr;
                mem_addr  = addr_hi;
                mem_wdata = q_opa & mask;
            end
            default: ;
        endcase
    end

    assign mem_dw  = q_dw;
    assign busy    = (state != S_IDLE);
    assign done    = (state == S_FIN);
    assign illegal = (state == S_FIN) && q_ill;
    assign result  = q_res;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic illegal,
    input logic mem_en,
    input logic mem_we
);

    // R12: memory is touched only inside a sequence
    a_r12_mem_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R12: the done cycle ends the sequence
    a_r12_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11: a sequence opens with a read (or finishes at once when illegal)
    a_r11_first_access_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((mem_en && !mem_we) || done));

    // R11: every write follows a read two cycles earlier or another write
    a_r11_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($past(mem_en && !mem_we, 2) || $past(mem_en && mem_we)));

    // R10: an undefined code finishes in the cycle after acceptance
    a_r10_illegal_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && $past(!busy)));

endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .mem_en  (mem_en),
    .mem_we  (mem_we)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

    localparam int AW = 8;
    localparam int DW = 64;
    localparam logic [63:0] NEG64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] NEG32 = 64'h0000_0000_8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [4:0]    req_func = '0;
    logic          req_store = 1'b0;
    logic          req_dw = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_opa = '0;
    logic [DW-1:0] req_opb = '0;
    logic          busy, done, illegal, mem_en, mem_we, mem_dw;
    logic [DW-1:0] result, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    logic [7:0] mem [0:255];

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    amo_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk, .rst_n, .req_valid, .req_func, .req_store, .req_dw,
        .req_addr, .req_opa, .req_opb, .busy, .done, .illegal, .result,
        .mem_en, .mem_we, .mem_dw, .mem_addr, .mem_wdata, .mem_rdata
    );

    // Synchronous byte-addressed memory model, little-endian
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int i = 0; i < 8; i++)
                    if (mem_dw || i < 4) mem[8'(mem_addr + 8'(i))] <= mem_wdata[8*i +: 8];
            end else begin
                for (int i = 0; i < 8; i++)
                    mem_rdata[8*i +: 8] <= (mem_dw || i < 4) ? mem[8'(mem_addr + 8'(i))] : 8'h00;
            end
        end
    end

    function automatic logic [63:0] peek(input logic [7:0] a, input logic dw);
        logic [63:0] v = '0;
        for (int i = 0; i < 8; i++)
            if (dw || i < 4) v[8*i +: 8] = mem[8'(a + 8'(i))];
        return v;
    endfunction

    task automatic poke(input logic [7:0] a, input logic dw, input logic [63:0] v);
        for (int i = 0; i < 8; i++)
            if (dw || i < 4) mem[8'(a + 8'(i))] = v[8*i +: 8];
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Runs one request; returns result, illegal flag, cycles to done, write count
    task automatic run_op(input logic [4:0] f, input logic st, input logic dw,
                          input logic [7:0] a, input logic [63:0] opa, input logic [63:0] opb,
                          output logic [63:0] res, output logic ill, output int lat, output int nwr);
        @(negedge clk);
        req_valid = 1'b1; req_func = f; req_store = st; req_dw = dw;
        req_addr = a; req_opa = opa; req_opb = opb;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; nwr = 0;
        forever begin
            lat++;
            if (mem_en && mem_we) nwr++;
            if (!busy) check("R12 busy during sequence", 64'(busy), 64'd1);
            if (done) break;
            if (lat > 40) begin
                check("R11 watchdog: done never rose", 64'(done), 64'd1);
                break;
            end
            @(negedge clk);
        end
        res = result; ill = illegal;
    endtask

    task automatic op_chk(input string tag, input logic [4:0] f, input logic st, input logic dw,
                          input logic [7:0] a, input logic [63:0] opa, input logic [63:0] opb,
                          input logic [63:0] exp_res, input int exp_lat, input int exp_wr);
        logic [63:0] res; logic ill; int lat, nwr;
        run_op(f, st, dw, a, opa, opb, res, ill, lat, nwr);
        check({tag, " result"}, res, exp_res);
        check({tag, " illegal"}, 64'(ill), 64'd0);
        check({tag, " R11 latency"}, 64'(lat), 64'(exp_lat));
        check({tag, " writes"}, 64'(nwr), 64'(exp_wr));
    endtask

    task automatic t_reset;
        check("R1 busy", 64'(busy), 0);
        check("R1 done", 64'(done), 0);
        check("R1 illegal", 64'(illegal), 0);
        check("R1 mem_en", 64'(mem_en), 0);
    endtask

    task automatic t_fetch64;
        poke(8'h40, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        op_chk("R2 add", 5'b00000, 0, 1, 8'h40, 64'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4, 1);
        check("R2 add mem", peek(8'h40, 1), 64'd1);
        poke(8'h40, 1, 64'hF0F0);
        op_chk("R2 xor", 5'b00001, 0, 1, 8'h40, 64'hFF00, 0, 64'hF0F0, 4, 1);
        check("R2 xor mem", peek(8'h40, 1), 64'h0FF0);
        poke(8'h40, 1, 64'h1);
        op_chk("R2 or", 5'b00010, 0, 1, 8'h40, 64'h10, 0, 64'h1, 4, 1);
        check("R2 or mem", peek(8'h40, 1), 64'h11);
        poke(8'h40, 1, 64'hFF);
        op_chk("R2 and", 5'b00011, 0, 1, 8'h40, 64'h0F, 0, 64'hFF, 4, 1);
        check("R2 and mem", peek(8'h40, 1), 64'h0F);
    endtask

    task automatic t_minmax64;
        poke(8'h40, 1, NEG64);
        op_chk("R2 umax", 5'b00100, 0, 1, 8'h40, 64'd5, 0, NEG64, 4, 1);
        check("R2 umax mem", peek(8'h40, 1), NEG64);
        op_chk("R2 smax", 5'b00101, 0, 1, 8'h40, 64'd5, 0, NEG64, 4, 1);
        check("R2 smax mem", peek(8'h40, 1), 64'd5);
        poke(8'h40, 1, NEG64);
        op_chk("R2 umin", 5'b00110, 0, 1, 8'h40, 64'd5, 0, NEG64, 4, 1);
        check("R2 umin mem", peek(8'h40, 1), 64'd5);
        poke(8'h40, 1, NEG64);
        op_chk("R2 smin", 5'b00111, 0, 1, 8'h40, 64'd5, 0, NEG64, 4, 1);
        check("R2 smin mem", peek(8'h40, 1), NEG64);
    endtask

    task automatic t_size32;
        poke(8'h84, 0, 64'hDEAD_BEEF);
        poke(8'h80, 0, 64'hFFFF_FFFE);
        op_chk("R13 smax32", 5'b00101, 0, 0, 8'h80, 64'd3, 0, 64'hFFFF_FFFE, 4, 1);
        check("R13 smax32 mem", peek(8'h80, 0), 64'd3);
        poke(8'h80, 0, 64'hFFFF_FFFE);
        op_chk("R13 umax32", 5'b00100, 0, 0, 8'h80, 64'd3, 0, 64'hFFFF_FFFE, 4, 1);
        check("R13 umax32 mem", peek(8'h80, 0), 64'hFFFF_FFFE);
        poke(8'h80, 0, 64'hFFFF_FFFF);
        op_chk("R13 add32", 5'b00000, 0, 0, 8'h80, 64'h1234_0000_0000_0001, 0, 64'hFFFF_FFFF, 4, 1);
        check("R13 add32 mem", peek(8'h80, 0), 64'd0);
        check("R13 neighbour untouched", peek(8'h84, 0), 64'hDEAD_BEEF);
    endtask

    task automatic t_swap;
        poke(8'h40, 1, 64'h1111);
        op_chk("R3 swap", 5'b01000, 0, 1, 8'h40, 64'h2222, 0, 64'h1111, 4, 1);
        check("R3 swap mem", peek(8'h40, 1), 64'h2222);
    endtask

    task automatic t_csne;
        poke(8'h40, 1, 64'd5);
        op_chk("R4 csne equal", 5'b10000, 0, 1, 8'h40, 64'd5, 64'd9, 64'd5, 4, 0);
        check("R4 csne equal mem", peek(8'h40, 1), 64'd5);
        op_chk("R4 csne differ", 5'b10000, 0, 1, 8'h40, 64'd7, 64'd9, 64'd5, 4, 1);
        check("R4 csne differ mem", peek(8'h40, 1), 64'd9);
    endtask

    task automatic t_incb;
        poke(8'h40, 1, 64'd3); poke(8'h48, 1, 64'd10);
        op_chk("R5 incb differ", 5'b11000, 0, 1, 8'h40, 0, 0, 64'd3, 5, 1);
        check("R5 incb mem", peek(8'h40, 1), 64'd4);
        check("R5 incb upper", peek(8'h48, 1), 64'd10);
        poke(8'h40, 1, 64'd10);
        op_chk("R5 incb equal", 5'b11000, 0, 1, 8'h40, 0, 0, NEG64, 5, 0);
        check("R5 incb equal mem", peek(8'h40, 1), 64'd10);
    endtask

    task automatic t_ince;
        poke(8'h40, 1, 64'd7); poke(8'h48, 1, 64'd7);
        op_chk("R6 ince equal", 5'b11001, 0, 1, 8'h40, 0, 0, 64'd7, 5, 1);
        check("R6 ince mem", peek(8'h40, 1), 64'd8);
        op_chk("R6 ince differ", 5'b11001, 0, 1, 8'h40, 0, 0, NEG64, 5, 0);
        check("R6 ince differ mem", peek(8'h40, 1), 64'd8);
    endtask

    task automatic t_decb;
        poke(8'h80, 0, 64'd2); poke(8'h84, 0, 64'd6);
        op_chk("R7 decb differ", 5'b11100, 0, 0, 8'h84, 0, 0, 64'd6, 5, 1);
        check("R7 decb mem", peek(8'h84, 0), 64'd5);
        check("R7 decb lower kept", peek(8'h80, 0), 64'd2);
        poke(8'h84, 0, 64'd2);
        op_chk("R7 decb equal", 5'b11100, 0, 0, 8'h84, 0, 0, NEG32, 5, 0);
        check("R7 decb equal mem", peek(8'h84, 0), 64'd2);
    endtask

    task automatic t_store;
        poke(8'h40, 1, 64'd10);
        op_chk("R8 store add", 5'b00000, 1, 1, 8'h40, 64'd5, 0, 64'd0, 4, 1);
        check("R8 store add mem", peek(8'h40, 1), 64'd15);
        poke(8'h80, 0, 64'd4);
        op_chk("R8 store smin32", 5'b00111, 1, 0, 8'h80, 64'hFFFF_FFFF, 0, 64'd0, 4, 1);
        check("R8 store smin32 mem", peek(8'h80, 0), 64'hFFFF_FFFF);
    endtask

    task automatic t_twin;
        poke(8'h40, 1, 64'd4); poke(8'h48, 1, 64'd4);
        op_chk("R9 twin equal", 5'b11000, 1, 1, 8'h40, 64'h99, 0, 64'd0, 6, 2);
        check("R9 twin low", peek(8'h40, 1), 64'h99);
        check("R9 twin high", peek(8'h48, 1), 64'h99);
        poke(8'h48, 1, 64'd1);
        op_chk("R9 twin differ", 5'b11000, 1, 1, 8'h40, 64'h55, 0, 64'd0, 6, 0);
        check("R9 twin differ low", peek(8'h40, 1), 64'h99);
        check("R9 twin differ high", peek(8'h48, 1), 64'd1);
    endtask

    task automatic t_illegal;
        logic [63:0] res; logic ill; int lat, nwr;
        logic [4:0] codes [3] = '{5'b01001, 5'b01000, 5'b11001};
        logic       sts   [3] = '{1'b0, 1'b1, 1'b1};
        poke(8'h40, 1, 64'h77);
        for (int k = 0; k < 3; k++) begin
            run_op(codes[k], sts[k], 1, 8'h40, 64'd1, 64'd2, res, ill, lat, nwr);
            check("R10 illegal flag", 64'(ill), 64'd1);
            check("R10 latency", 64'(lat), 64'd1);
            check("R10 no write", 64'(nwr), 64'd0);
            check("R10 result", res, 64'd0);
        end
        check("R10 mem kept", peek(8'h40, 1), 64'h77);
    endtask

    task automatic t_ignore;
        int cyc = 0;
        poke(8'h40, 1, 64'd1); poke(8'h60, 1, 64'h55);
        @(negedge clk);
        req_valid = 1'b1; req_func = 5'b00000; req_store = 0; req_dw = 1;
        req_addr = 8'h40; req_opa = 64'd1;
        @(negedge clk);
        req_func = 5'b01000; req_addr = 8'h60; req_opa = 64'hAA;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 40) begin @(negedge clk); cyc++; end
        check("R12 done reached", 64'(done), 64'd1);
        @(negedge clk);
        check("R12 idle after done", 64'(busy), 64'd0);
        check("R12 first op applied", peek(8'h40, 1), 64'd2);
        check("R12 request during busy ignored", peek(8'h60, 1), 64'h55);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fetch64;
        t_minmax64;
        t_size32;
        t_swap;
        t_csne;
        t_incb;
        t_ince;
        t_decb;
        t_store;
        t_twin;
        t_illegal;
        t_ignore;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule